// File: doc/BRIEF.md
# Cache Region Maintenance Engine

This block drives maintenance of a second-level cache over a range of line addresses. Software sets the operation flavour in a control register, loads a region end address, and then writes the region start address; that start write is the launch. The engine then walks every line-aligned address of the region and hands out one maintenance request per line on a valid/ready port. The cache, its tags and the agent that accepts those requests are outside the block.

Two further trigger registers start a walk over the whole cache, from address zero up to the cache size, either as a flush or as an invalidate. The invalidate flavour is turned into a flush-then-invalidate when the mode bit is set. The line size is 128 bytes or 64 bytes, chosen by a configuration input and sampled at launch. A busy flag in the control register lets software poll for completion. While busy is set, every register write and trigger is dropped.

Register select encoding on `reg_sel`: 0 control, 1 region end, 2 region start (launch), 3 whole-cache flush trigger, 4 whole-cache invalidate trigger.

Top module: `maint_region_engine`

## Requirements
- R1: After reset `ctrl_rdata` reads 0 and `req_valid` is 0.
- R2: The control register stores bit 0 (cache off), bit 6 (mode) and bits 11..9 (region code). Bit 8 reads the busy flag and ignores writes. Every other bit reads 0.
- R3: For a region walk, `req_op` is 2'b10 (invalidate) when the region code is 3'b001 and the mode bit is 0. It is 2'b11 (flush then invalidate) when the code is 3'b001 and the mode bit is 1. For every other code it is 2'b01 (flush).
- R4: A write to the start register launches a region walk against the end register written earlier. Requests go to floor(start), floor(start)+L, and so on, each after an accepted handshake. The walk ends with the last aligned address below floor(end). The low address bits of both registers are ignored.
- R5: The line size L is 128 bytes when `cfg_lsz` is 0 and 64 bytes when it is 1, sampled in the launch cycle. Every request address is a multiple of L.
- R6: A start write for which floor(start) >= floor(end) issues no request and leaves busy at 0.
- R7: A write with data bit 0 = 1 to select 4 walks addresses 0 to CACHE_BYTES−L with op 2'b10, or with op 2'b11 when the mode bit is 1. The same write to select 3 walks them with op 2'b01. A trigger write with bit 0 = 0 does nothing.
- R8: The busy flag (control bit 8) reads 1 from the cycle after a launching write. It reads 0 from the clock edge that accepts the last request onward.
- R9: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_addr` and `req_op` hold.
- R10: While busy is 1, writes to the control, end and start registers and to both triggers are ignored.
- R11: While control bit 0 is 1, start writes and both triggers launch nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 ctrl, 1 end, 2 start, 3 flush all, 4 invalidate all) |
| reg_wdata | input | 32 | Write data |
| ctrl_rdata | output | 32 | Control register readback with busy in bit 8 |
| cfg_lsz | input | 1 | Line size select: 0 gives 128 bytes, 1 gives 64 bytes |
| req_valid | output | 1 | Maintenance request valid |
| req_ready | input | 1 | Request accepted by the responder |
| req_addr | output | AW | Line address of the request |
| req_op | output | 2 | 01 flush, 10 invalidate, 11 flush then invalidate |

## Verification
The assertions assume that `req_ready` may change freely but is only acted upon while `req_valid` is high. They also assume that CACHE_BYTES is a multiple of 128 and fits in AW bits, so every walk ends on a line boundary without wrapping. The stimulus respects this. It programs the end register before each start write and keeps every region well inside the address space. It changes `cfg_lsz` only between operations. It throttles `req_ready` with fixed stall patterns rather than random ones, so the hold rule and the busy fall after the last accepted request are both exercised.

// File: rtl/maint_pkg.sv
package maint_pkg;

  typedef enum logic [1:0] {
    MOP_NONE      = 2'b00,
    MOP_FLUSH     = 2'b01,
    MOP_INV       = 2'b10,
    MOP_FLUSH_INV = 2'b11
  } maint_op_e;

  typedef logic [2:0] shamt_t;

  localparam logic [2:0] SEL_CTRL      = 3'd0;
  localparam logic [2:0] SEL_END       = 3'd1;
  localparam logic [2:0] SEL_START     = 3'd2;
  localparam logic [2:0] SEL_FLUSH_ALL = 3'd3;
  localparam logic [2:0] SEL_INV_ALL   = 3'd4;

  // log2 of the line size: 128 bytes for field 0, 64 bytes otherwise
  function automatic shamt_t line_shift(input logic lsz);
    return lsz ? shamt_t'(6) : shamt_t'(7);
  endfunction

  // region code 001 selects invalidate flavour, anything else flushes
  function automatic maint_op_e region_op(input logic [2:0] code, input logic mode);
    if (code == 3'b001) return mode ? MOP_FLUSH_INV : MOP_INV;
    return MOP_FLUSH;
  endfunction

  function automatic maint_op_e whole_inv_op(input logic mode);
    return mode ? MOP_FLUSH_INV : MOP_INV;
  endfunction

endpackage

// File: rtl/maint_regs.sv
module maint_regs
  import maint_pkg::*;
#(
  parameter int AW          = 32,
  parameter int CACHE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [2:0]    sel,
  input  logic [31:0]   wdata,
  input  logic          busy,
  input  logic          cfg_lsz,
  output logic [31:0]   ctrl_rdata,
  output logic          launch,
  output logic [AW-1:0] launch_base,
  output logic [AW-1:0] launch_stop,
  output maint_op_e     launch_op,
  output shamt_t        launch_shift
);

  localparam logic [AW-1:0] WHOLE_STOP = AW'(CACHE_BYTES);

  logic          dis_q, mode_q;
  logic [2:0]    code_q;
  logic [AW-1:0] end_q;
  logic          accept;
  logic [AW-1:0] mask, start_al, end_al;
  logic          region_go, whole_go;

  function automatic logic [AW-1:0] line_mask(input shamt_t sh);
    return ~((AW'(1) << sh) - AW'(1));
  endfunction

  assign accept = we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q  <= 1'b0;
      mode_q <= 1'b0;
      code_q <= 3'b000;
      end_q  <= '0;
    end else begin
      if (accept && sel == SEL_CTRL) begin
        dis_q  <= wdata[0];
        mode_q <= wdata[6];
        code_q <= wdata[11:9];
      end
      if (accept && sel == SEL_END) end_q <= wdata[AW-1:0];
    end
  end

  always_comb begin
    launch_shift = line_shift(cfg_lsz);
    mask         = line_mask(launch_shift);
    start_al     = wdata[AW-1:0] & mask;
    end_al       = end_q & mask;
    region_go    = accept && !dis_q && sel == SEL_START && (start_al < end_al);
    whole_go     = accept && !dis_q && wdata[0] &&
                   (sel == SEL_FLUSH_ALL || sel == SEL_INV_ALL);
    launch       = region_go || whole_go;
    launch_base  = region_go ? start_al : '0;
    launch_stop  = region_go ? end_al : WHOLE_STOP;
    if (region_go)              launch_op = region_op(code_q, mode_q);
    else if (sel == SEL_INV_ALL) launch_op = whole_inv_op(mode_q);
    else                         launch_op = MOP_FLUSH;
  end

  assign ctrl_rdata = {20'b0, code_q, busy, 1'b0, mode_q, 5'b0, dis_q};

endmodule

// File: rtl/maint_walk.sv
module maint_walk
  import maint_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] stop,
  input  maint_op_e     op,
  input  shamt_t        shift,
  input  logic          req_ready,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output logic [1:0]    req_op,
  output logic          busy,
  output logic          hs,
  output logic          last_hs,
  output logic [AW-1:0] step
);

  logic          busy_q;
  logic [AW-1:0] cur_q, stop_q;
  maint_op_e     op_q;
  shamt_t        shift_q;
  logic [AW:0]   next_addr;

  function automatic logic [AW:0] advance(input logic [AW-1:0] a, input logic [AW-1:0] s);
    return {1'b0, a} + {1'b0, s};
  endfunction

  assign step      = AW'(1) << shift_q;
  assign next_addr = advance(cur_q, step);
  assign hs        = busy_q && req_ready;
  assign last_hs   = hs && (next_addr >= {1'b0, stop_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cur_q   <= '0;
      stop_q  <= '0;
      op_q    <= MOP_NONE;
      shift_q <= shamt_t'(7);
    end else if (launch) begin
      busy_q  <= 1'b1;
      cur_q   <= base;
      stop_q  <= stop;
      op_q    <= op;
      shift_q <= shift;
    end else if (hs) begin
      if (last_hs) busy_q <= 1'b0;
      else         cur_q  <= next_addr[AW-1:0];
    end
  end

  assign busy      = busy_q;
  assign req_valid = busy_q;
  assign req_addr  = cur_q;
  assign req_op    = busy_q ? op_q : MOP_NONE;

endmodule

// File: rtl/maint_region_engine.sv
module maint_region_engine
  import maint_pkg::*;
#(
  parameter int AW          = 32,
  parameter int CACHE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   ctrl_rdata,
  input  logic          cfg_lsz,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [1:0]    req_op
);

  logic          busy, launch, hs, last_hs;
  logic [AW-1:0] launch_base, launch_stop, step;
  maint_op_e     launch_op;
  shamt_t        launch_shift;

  maint_regs #(.AW(AW), .CACHE_BYTES(CACHE_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .busy(busy), .cfg_lsz(cfg_lsz), .ctrl_rdata(ctrl_rdata), .launch(launch),
    .launch_base(launch_base), .launch_stop(launch_stop),
    .launch_op(launch_op), .launch_shift(launch_shift)
  );

  maint_walk #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n), .launch(launch), .base(launch_base),
    .stop(launch_stop), .op(launch_op), .shift(launch_shift),
    .req_ready(req_ready), .req_valid(req_valid), .req_addr(req_addr),
    .req_op(req_op), .busy(busy), .hs(hs), .last_hs(last_hs), .step(step)
  );

endmodule

// File: rtl/maint_region_engine_chk.sv
module maint_region_engine_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_bit,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_op,
  input logic          launch,
  input logic          hs,
  input logic          last_hs,
  input logic [AW-1:0] step
);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_op));

  p_stride_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hs && !last_hs |=> req_valid && (req_addr == $past(req_addr) + $past(step)));

  p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_hs && !launch |=> !busy_bit && !req_valid);

  p_launch_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy_bit);

  p_idle_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !busy_bit);

  p_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[5:0] == 6'd0);

  p_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_op != 2'b00);

endmodule

bind maint_region_engine maint_region_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_bit(ctrl_rdata[8]), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .req_op(req_op),
  .launch(launch), .hs(hs), .last_hs(last_hs), .step(step)
);

// File: tb/maint_region_engine_bench.sv
module maint_region_engine_bench;

  localparam int AW = 32;
  localparam int CB = 4096;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_sel = 3'd0;
  logic [31:0]   reg_wdata = 32'd0;
  logic [31:0]   ctrl_rdata;
  logic          cfg_lsz = 1'b0;
  logic          req_valid;
  logic          req_ready = 1'b0;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_op;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int stall_mode = 0;
  bit chk_idle = 0;
  logic [33:0] exp_q[$];

  always #2 clk = ~clk;

  maint_region_engine #(.AW(AW), .CACHE_BYTES(CB)) u_maint_region_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .cfg_lsz(cfg_lsz),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_op(req_op)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every handshake the next edge will take
  always @(negedge clk) begin
    logic [33:0] item;
    cyc++;
    if (rst_n) begin
      if (chk_idle) begin
        chk_idle = 0;
        chk(!ctrl_rdata[8] && !req_valid, "R8 busy clear after last accept",
            {ctrl_rdata[8], req_valid}, 0);
      end
      case (stall_mode)
        0: req_ready = 1'b1;
        1: req_ready = (cyc % 3) != 0;
        default: req_ready = (cyc % 5) == 4;
      endcase
      if (req_valid && req_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4 unexpected request", {req_op, req_addr}, 0);
        end else begin
          item = exp_q.pop_front();
          chk({req_op, req_addr} == item, "R4/R3 request addr+op", {req_op, req_addr}, item);
          if (exp_q.size() == 0) chk_idle = 1;
        end
      end
    end
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic push_walk(input longint lo, input longint hi, input int l, input logic [1:0] op);
    for (longint a = lo & ~longint'(l - 1); a < (hi & ~longint'(l - 1)); a += l)
      exp_q.push_back({op, a[31:0]});
  endtask

  task automatic wait_idle(input string req);
    for (int i = 0; i < 3000 && (ctrl_rdata[8] || exp_q.size() != 0); i++) @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0 && !ctrl_rdata[8], req, exp_q.size(), 0);
  endtask

  function automatic logic [1:0] exp_region_op(input logic [31:0] c);
    if (c[11:9] == 3'b001) return c[6] ? 2'b11 : 2'b10;
    return 2'b01;
  endfunction

  task automatic run_region(input logic [31:0] c, input longint s, input longint sz,
                            input bit lsz, input string req);
    int l;
    longint e;
    l = lsz ? 64 : 128;
    e = s + sz + l - 1;
    cfg_lsz = lsz;
    wr(3'd0, c);
    push_walk(s, e, l, exp_region_op(c));
    wr(3'd1, e[31:0]);
    wr(3'd2, s[31:0]);
    chk(ctrl_rdata[8] == 1'b1, "R8 busy after start write", ctrl_rdata[8], 1);
    wait_idle(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    fails++;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ctrl_rdata == 32'd0, "R1 ctrl reset", ctrl_rdata, 0);
    chk(req_valid == 1'b0, "R1 valid reset", req_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 writable fields
    wr(3'd0, 32'hFFFF_FFFF);
    chk(ctrl_rdata == 32'h0000_0E41, "R2 ctrl fields", ctrl_rdata, 32'hE41);
    wr(3'd0, 32'd0);
    chk(ctrl_rdata == 32'd0, "R2 ctrl clear", ctrl_rdata, 0);

    // R4/R5 region flush with 128-byte lines
    stall_mode = 0;
    run_region(32'h0000_0000, 64'h1010, 64'h200, 1'b0, "R4 region flush L128 done");
    // R3 invalidate, R5 64-byte lines, stalled responder (R9)
    stall_mode = 1;
    run_region(32'h0000_0200, 64'h2024, 64'h1C0, 1'b1, "R3 invalidate L64 done");
    // R3 flush then invalidate
    run_region(32'h0000_0240, 64'h2F80, 64'h100, 1'b0, "R3 flush-inv done");
    // R3 other code acts as flush
    stall_mode = 2;
    run_region(32'h0000_0A40, 64'h0040, 64'h0C0, 1'b1, "R3 code 101 flush done");

    // R6 empty range: start in same line as end
    stall_mode = 0;
    cfg_lsz = 1'b0;
    wr(3'd1, 32'h0000_2000);
    wr(3'd2, 32'h0000_2010);
    chk(!ctrl_rdata[8] && !req_valid, "R6 empty range no launch", ctrl_rdata[8], 0);
    repeat (3) @(negedge clk);
    chk(!req_valid, "R6 still idle", req_valid, 0);

    // R7 whole-cache flush, 128-byte lines
    wr(3'd0, 32'd0);
    push_walk(0, CB, 128, 2'b01);
    wr(3'd3, 32'd1);
    chk(ctrl_rdata[8], "R8 busy after whole flush", ctrl_rdata[8], 1);
    wait_idle("R7 whole flush done");
    // R7 whole invalidate with mode bit -> flush-inv, 64-byte lines
    stall_mode = 1;
    cfg_lsz = 1'b1;
    wr(3'd0, 32'h0000_0040);
    push_walk(0, CB, 64, 2'b11);
    wr(3'd4, 32'd1);
    wait_idle("R7 whole flush-inv done");
    // R7 whole invalidate plain
    wr(3'd0, 32'd0);
    push_walk(0, CB, 64, 2'b10);
    wr(3'd4, 32'd1);
    wait_idle("R7 whole invalidate done");
    // R7 trigger with bit0 = 0
    wr(3'd4, 32'd0);
    chk(!ctrl_rdata[8], "R7 zero trigger ignored", ctrl_rdata[8], 0);
    wr(3'd3, 32'h0000_0002);
    chk(!ctrl_rdata[8], "R7 zero flush trigger ignored", ctrl_rdata[8], 0);

    // R10 writes while busy are dropped
    stall_mode = 2;
    cfg_lsz = 1'b1;
    push_walk(64'h3400, 64'h383F, 64, 2'b01);
    wr(3'd1, 32'h0000_383F);
    wr(3'd2, 32'h0000_3400);
    wr(3'd1, 32'h0000_9000);
    wr(3'd0, 32'h0000_0241);
    wr(3'd2, 32'h0000_8000);
    wr(3'd4, 32'd1);
    wait_idle("R10 walk unaffected");
    chk(ctrl_rdata == 32'd0, "R10 ctrl unchanged", ctrl_rdata, 0);
    stall_mode = 0;
    push_walk(64'h3600, 64'h383F, 64, 2'b01);
    wr(3'd2, 32'h0000_3600);
    wait_idle("R10 end register kept");

    // R11 cache off blocks launches
    wr(3'd0, 32'd1);
    chk(ctrl_rdata == 32'd1, "R11 off bit", ctrl_rdata, 1);
    wr(3'd1, 32'h0000_5000);
    wr(3'd2, 32'h0000_4000);
    chk(!ctrl_rdata[8], "R11 region blocked", ctrl_rdata[8], 0);
    wr(3'd4, 32'd1);
    wr(3'd3, 32'd1);
    repeat (3) @(negedge clk);
    chk(!ctrl_rdata[8] && !req_valid, "R11 whole blocked", req_valid, 0);
    wr(3'd0, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule